// File: doc/BRIEF.md
# Transfer Ring Doorbell Tracker

This block sits on the device side of a host-to-device work queue. Each logical channel owns one circular transfer ring in host memory. The host fills ring elements, moves the channel's write index forward, and then rings a per-channel doorbell. The tracker keeps the base address, the programmed last index, the read index and the write index for every supported channel. It reports per-ring empty and full status and hands the next element address to a downstream fetch engine over a valid/ready handshake.

One descriptor may span several ring elements. The fetch engine returns a chain bit with each element it accepts. While that bit is set, the tracker stays on the same channel until the descriptor ends, and it waits there if the ring runs dry in the middle. At descriptor boundaries it picks among the armed, non-empty channels in round-robin order. A channel becomes armed only when the host rings its doorbell. The channel number space is 8 bits wide, while the implementation supports `NUM_CH` channels. A doorbell that cannot be honoured is dropped and leaves a sticky error flag.

Top module: `xfer_ring_tracker`

## Requirements
- R1: After reset every channel is disabled, its last index is the maximum (2^IDX_W - 1), its read and write indices are 0, ring_empty is all ones, ring_full is all zeros, db_err is 0 and fetch_valid is 0.
- R2: A ring is reported empty when its read index equals its write index. It is reported full when the write index stepped once equals the read index. A step from the programmed last index wraps to 0.
- R3: A configuration write (cfg_we) to channel cfg_ch takes cfg_sel: 0 sets the base address, 1 the last index, 2 the read index, 3 the write index, and 4 the enable from cfg_data bit 0. Writes to channel numbers at or above NUM_CH are ignored. Clearing enable stops any fetch on that channel and keeps its indices.
- R4: No fetch is offered for a channel until a doorbell has armed it; moving the write index by configuration alone does not start work. A doorbell sampled at clock edge k produces fetch_valid after edge k+1.
- R5: A doorbell (db_we) whose channel is at or above NUM_CH, whose channel is disabled, or whose db_wp exceeds that channel's last index is ignored and sets db_err. db_err then stays at 1 until reset.
- R6: While fetch_valid is 1, fetch_ch is the channel number and fetch_addr equals base + read index * ELEM_BYTES.
- R7: The read index moves forward by one (with wrap) only when fetch_valid and fetch_ready are both 1. While fetch_ready is 0, with no configuration or doorbell write, the offered fetch and its address are held.
- R8: When an element is accepted with fetch_chain = 1, the next fetch is on the same channel with fetch_first = 0. If that ring is empty, the tracker waits for more elements on the same channel and serves no other channel. fetch_first is 1 on the first element of each descriptor.
- R9: At descriptor boundaries the next channel is chosen in round-robin order starting after the channel that last completed a descriptor.
- R10: When a descriptor ends and the ring is then empty, the channel is disarmed and fetch_valid goes to 0 until a new doorbell arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_NUM_W | Channel number for configuration |
| cfg_sel | input | 3 | Field select: 0 base, 1 last index, 2 read index, 3 write index, 4 enable |
| cfg_data | input | ADDR_W | Configuration value |
| db_we | input | 1 | Doorbell write strobe |
| db_ch | input | CH_NUM_W | Doorbell channel number |
| db_wp | input | IDX_W | New write index carried by the doorbell |
| ring_empty | output | NUM_CH | Per-channel empty status |
| ring_full | output | NUM_CH | Per-channel full status |
| db_err | output | 1 | Sticky flag for a rejected doorbell |
| fetch_valid | output | 1 | An element fetch is offered |
| fetch_ready | input | 1 | Fetch engine accepts the element |
| fetch_ch | output | CH_NUM_W | Channel of the offered element |
| fetch_addr | output | ADDR_W | Byte address of the offered element |
| fetch_first | output | 1 | Offered element starts a descriptor |
| fetch_chain | input | 1 | Chain bit of the element being accepted |

## Verification
The assertions watch on every cycle that the read index moves only when an element is accepted on a non-empty ring, that at most one ring advances per cycle, that a stalled offer holds its channel and address, that a chained acceptance keeps the channel, and that a rejected doorbell raises the error flag and the flag never falls. The ordering across channels, the wait on a ring that runs dry in the middle of a descriptor, wrap-around at the programmed length, the doorbell-to-valid latency and the rule that configuration alone starts no work come only from the bench's scenarios. The bench's reference model tracks indices, arming and descriptor lock and compares status and every offered element against them.

// File: rtl/xrt_pkg.sv
package xrt_pkg;

  typedef enum logic [2:0] {
    CFG_BASE   = 3'd0,
    CFG_LAST   = 3'd1,
    CFG_RDPTR  = 3'd2,
    CFG_WRPTR  = 3'd3,
    CFG_ENABLE = 3'd4
  } cfg_sel_e;

  // One step around a ring whose highest valid index is last_idx.
  function automatic int unsigned ring_step(int unsigned ptr, int unsigned last_idx);
    if (ptr >= last_idx) return 0;
    return ptr + 1;
  endfunction

  // Byte offset of element idx when each element is 2**shift bytes.
  function automatic logic [63:0] elem_byte_off(int unsigned idx, int unsigned shift);
    return 64'(idx) << shift;
  endfunction

  // Round-robin choice: first requester after prev, among n slots; -1 if none.
  function automatic int pick_rr(logic [255:0] req, int unsigned prev, int unsigned n);
    int res;
    res = -1;
    for (int unsigned k = 1; k <= 256; k++) begin
      if (k <= n && res < 0) begin
        if (req[(prev + k) % n]) res = int'((prev + k) % n);
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/xrt_ring_ctx.sv
module xrt_ring_ctx
  import xrt_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hit,
  input  cfg_sel_e          cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              db_hit,
  input  logic [IDX_W-1:0]  db_wp,
  input  logic              adv,
  input  logic              adv_chain,
  output logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  last_idx,
  output logic              enabled,
  output logic              armed,
  output logic              empty,
  output logic              full
);

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  rp_q, wp_q, last_q;
  logic              en_q, arm_q;
  logic [IDX_W-1:0]  rp_step, wp_step;
  logic              drained;
  logic              cfg_rp_wr, cfg_wp_wr, cfg_disable;

  assign rp_step     = IDX_W'(ring_step(32'(rp_q), 32'(last_q)));
  assign wp_step     = IDX_W'(ring_step(32'(wp_q), 32'(last_q)));
  assign drained     = adv && !adv_chain && (rp_step == wp_q);
  assign cfg_rp_wr   = cfg_hit && (cfg_sel == CFG_RDPTR);
  assign cfg_wp_wr   = cfg_hit && (cfg_sel == CFG_WRPTR);
  assign cfg_disable = cfg_hit && (cfg_sel == CFG_ENABLE) && !cfg_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '1;
      rp_q   <= '0;
      wp_q   <= '0;
      en_q   <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (cfg_hit && cfg_sel == CFG_BASE)   base_q <= cfg_data;
      if (cfg_hit && cfg_sel == CFG_LAST)   last_q <= cfg_data[IDX_W-1:0];
      if (cfg_hit && cfg_sel == CFG_ENABLE) en_q   <= cfg_data[0];
      if (cfg_rp_wr)   rp_q <= cfg_data[IDX_W-1:0];
      else if (adv)    rp_q <= rp_step;
      if (cfg_wp_wr)   wp_q <= cfg_data[IDX_W-1:0];
      else if (db_hit) wp_q <= db_wp;
      if (cfg_disable)  arm_q <= 1'b0;
      else if (db_hit)  arm_q <= 1'b1;
      else if (drained) arm_q <= 1'b0;
    end
  end

  assign base     = base_q;
  assign rd_idx   = rp_q;
  assign last_idx = last_q;
  assign enabled  = en_q;
  assign armed    = arm_q;
  assign empty    = (rp_q == wp_q);
  assign full     = (wp_step == rp_q);

  // R7: an accepted element always comes from a ring holding work
  assert_adv_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !empty);

  // R7: the read index is still unless an element is accepted or it is programmed
  assert_rp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !cfg_rp_wr) |=> $stable(rd_idx));

endmodule

// File: rtl/xrt_db_check.sv
module xrt_db_check #(
  parameter int NUM_CH   = 4,
  parameter int IDX_W    = 8,
  parameter int CH_NUM_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    db_we,
  input  logic [CH_NUM_W-1:0]     db_ch,
  input  logic [IDX_W-1:0]        db_wp,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH*IDX_W-1:0] ch_last,
  output logic [NUM_CH-1:0]       db_hit,
  output logic                    db_err
);

  logic db_bad;
  logic err_q;

  always_comb begin
    db_hit = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (db_we && db_ch == CH_NUM_W'(i) && ch_en[i] &&
          db_wp <= ch_last[i*IDX_W +: IDX_W])
        db_hit[i] = 1'b1;
    end
    db_bad = db_we && (db_hit == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (db_bad) err_q <= 1'b1;
  end

  assign db_err = err_q;

  // R5: the error flag never falls outside reset
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |=> db_err);

  // R5: a doorbell no ring took raises the flag
  assert_rejected_db_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (db_we && db_hit == '0) |=> db_err);

  // R5: at most one ring takes a given doorbell
  assert_db_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(db_hit));

endmodule

// File: rtl/xrt_fetch_sched.sv
module xrt_fetch_sched
  import xrt_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_IDX_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ch_en,
  input  logic [NUM_CH-1:0]   ch_armed,
  input  logic [NUM_CH-1:0]   ch_empty,
  input  logic                fetch_ready,
  input  logic                fetch_chain,
  output logic                fetch_valid,
  output logic                fetch_first,
  output logic [CH_IDX_W-1:0] grant_ch,
  output logic [NUM_CH-1:0]   adv
);

  logic                grant_vld;
  logic [CH_IDX_W-1:0] grant_q;
  logic [CH_IDX_W-1:0] prev_q;
  logic                locked;
  logic [NUM_CH-1:0]   eligible;
  logic                accept;
  logic                release_grant;
  int                  pick;

  assign eligible    = ch_en & ch_armed & ~ch_empty;
  assign pick        = pick_rr(256'(eligible), 32'(prev_q), NUM_CH);
  assign fetch_valid = grant_vld && ch_en[grant_q] && !ch_empty[grant_q];
  assign accept      = fetch_valid && fetch_ready;
  assign release_grant = locked ? !ch_en[grant_q]
                                : !(ch_en[grant_q] && !ch_empty[grant_q]);

  always_comb begin
    adv = '0;
    if (accept) adv[grant_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_vld <= 1'b0;
      grant_q   <= '0;
      prev_q    <= CH_IDX_W'(NUM_CH - 1);
      locked    <= 1'b0;
    end else if (grant_vld) begin
      if (accept) begin
        if (fetch_chain) begin
          locked <= 1'b1;
        end else begin
          locked    <= 1'b0;
          grant_vld <= 1'b0;
          prev_q    <= grant_q;
        end
      end else if (release_grant) begin
        grant_vld <= 1'b0;
        locked    <= 1'b0;
      end
    end else if (pick >= 0) begin
      grant_vld <= 1'b1;
      grant_q   <= CH_IDX_W'(pick);
    end
  end

  assign fetch_first = !locked;
  assign grant_ch    = grant_q;

  // R9: one ring advances at most per cycle
  assert_single_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adv));

  // R8: a chained acceptance keeps the same channel for the next element
  assert_chain_keeps_ch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fetch_chain) |=> (grant_ch == $past(grant_ch)));

  // R4: nothing is offered on a channel that was never armed and is not mid-descriptor
  assert_offer_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_first) |-> ch_armed[grant_ch]);

endmodule

// File: rtl/xfer_ring_tracker.sv
module xfer_ring_tracker
  import xrt_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int IDX_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int ELEM_BYTES = 16,
  parameter int CH_NUM_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CH_NUM_W-1:0] cfg_ch,
  input  logic [2:0]          cfg_sel,
  input  logic [ADDR_W-1:0]   cfg_data,
  input  logic                db_we,
  input  logic [CH_NUM_W-1:0] db_ch,
  input  logic [IDX_W-1:0]    db_wp,
  output logic [NUM_CH-1:0]   ring_empty,
  output logic [NUM_CH-1:0]   ring_full,
  output logic                db_err,
  output logic                fetch_valid,
  input  logic                fetch_ready,
  output logic [CH_NUM_W-1:0] fetch_ch,
  output logic [ADDR_W-1:0]   fetch_addr,
  output logic                fetch_first,
  input  logic                fetch_chain
);

  localparam int CH_IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int ELEM_SHIFT = $clog2(ELEM_BYTES);

  logic [ADDR_W-1:0]       base_a [NUM_CH];
  logic [IDX_W-1:0]        rp_a   [NUM_CH];
  logic [NUM_CH*IDX_W-1:0] last_flat;
  logic [NUM_CH-1:0]       en_v, arm_v, empty_v, full_v;
  logic [NUM_CH-1:0]       db_hit, adv, cfg_hit;
  logic [CH_IDX_W-1:0]     grant_ch;
  cfg_sel_e                sel;

  assign sel = cfg_sel_e'(cfg_sel);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ring
      assign cfg_hit[i] = cfg_we && (cfg_ch == CH_NUM_W'(i));
      xrt_ring_ctx #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_hit   (cfg_hit[i]),
        .cfg_sel   (sel),
        .cfg_data  (cfg_data),
        .db_hit    (db_hit[i]),
        .db_wp     (db_wp),
        .adv       (adv[i]),
        .adv_chain (fetch_chain),
        .base      (base_a[i]),
        .rd_idx    (rp_a[i]),
        .last_idx  (last_flat[i*IDX_W +: IDX_W]),
        .enabled   (en_v[i]),
        .armed     (arm_v[i]),
        .empty     (empty_v[i]),
        .full      (full_v[i])
      );
    end
  endgenerate

  xrt_db_check #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .CH_NUM_W(CH_NUM_W)) i_db (
    .clk     (clk),
    .rst_n   (rst_n),
    .db_we   (db_we),
    .db_ch   (db_ch),
    .db_wp   (db_wp),
    .ch_en   (en_v),
    .ch_last (last_flat),
    .db_hit  (db_hit),
    .db_err  (db_err)
  );

  xrt_fetch_sched #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) i_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en       (en_v),
    .ch_armed    (arm_v),
    .ch_empty    (empty_v),
    .fetch_ready (fetch_ready),
    .fetch_chain (fetch_chain),
    .fetch_valid (fetch_valid),
    .fetch_first (fetch_first),
    .grant_ch    (grant_ch),
    .adv         (adv)
  );

  assign ring_empty = empty_v;
  assign ring_full  = full_v;
  assign fetch_ch   = CH_NUM_W'(grant_ch);
  assign fetch_addr = base_a[grant_ch] +
                      ADDR_W'(elem_byte_off(32'(rp_a[grant_ch]), ELEM_SHIFT));

  // R7: a stalled offer keeps its channel and address when nothing is reprogrammed
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !cfg_we && !db_we) |=>
      (fetch_valid && $stable(fetch_addr) && $stable(fetch_ch)));

endmodule

// File: tb/test_xfer_ring_tracker.sv
`timescale 1ns/1ps
module test_xfer_ring_tracker;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_ch = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        db_we = 1'b0;
  logic [7:0]  db_ch = '0;
  logic [7:0]  db_wp = '0;
  logic [N-1:0] ring_empty, ring_full;
  logic        db_err, fetch_valid, fetch_first, fetch_chain;
  logic        fetch_ready = 1'b0;
  logic [7:0]  fetch_ch;
  logic [31:0] fetch_addr;
  logic [7:0]  chain_mask = '0;

  always #2.5 clk = ~clk;

  // chain bit of the element being offered: bit of the mask at its ring index
  assign fetch_chain = chain_mask[fetch_addr[6:4]];

  xfer_ring_tracker i_xfer_ring_tracker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .db_we(db_we), .db_ch(db_ch), .db_wp(db_wp),
    .ring_empty(ring_empty), .ring_full(ring_full), .db_err(db_err),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_ch(fetch_ch),
    .fetch_addr(fetch_addr), .fetch_first(fetch_first), .fetch_chain(fetch_chain)
  );

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference
  int  mbase[N], mlast[N], mrp[N], mwp[N];
  bit  men[N], marm[N];
  bit  merr, mlocked;
  int  mlck;
  int  served[$];
  int  hs_cnt = 0, fv_cnt = 0, ch1_hs = 0;
  longint last_ch1_addr = 0;

  function automatic int nxt(int p, int l);
    int r;
    r = p + 1;
    if (p == l) r = 0;
    return r;
  endfunction

  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin
        mbase[c] = 0; mlast[c] = 255; mrp[c] = 0; mwp[c] = 0; men[c] = 0; marm[c] = 0;
      end
      merr = 0; mlocked = 0; mlck = 0;
    end else begin
      bit db_ok;
      int dc;
      for (int c = 0; c < N; c++) begin
        chk(ring_empty[c] == (mrp[c] == mwp[c]), "R2 empty", ring_empty[c], mrp[c] == mwp[c]);
        chk(ring_full[c] == (nxt(mwp[c], mlast[c]) == mrp[c]), "R2 full",
            ring_full[c], nxt(mwp[c], mlast[c]) == mrp[c]);
      end
      chk(db_err == merr, "R5 err", db_err, merr);
      if (fetch_valid) begin
        fv_cnt++;
        dc = int'(fetch_ch);
        chk(dc < N && men[dc] && mrp[dc] != mwp[dc], "R10 offer on live ring", dc, 0);
        if (dc < N) begin
          chk(fetch_addr == 32'(mbase[dc] + mrp[dc] * 16), "R6 addr", fetch_addr,
              mbase[dc] + mrp[dc] * 16);
          chk(fetch_first == !mlocked, "R8 first", fetch_first, !mlocked);
          if (mlocked) chk(dc == mlck, "R8 locked channel", dc, mlck);
          else chk(marm[dc], "R4 armed", marm[dc], 1);
        end
      end
      // next state, as of the coming edge
      db_ok = db_we && db_ch < N;
      if (db_ok) db_ok = men[db_ch] && int'(db_wp) <= mlast[db_ch];
      if (fetch_valid && fetch_ready && fetch_ch < N) begin
        dc = int'(fetch_ch);
        hs_cnt++;
        if (dc == 1) begin ch1_hs++; last_ch1_addr = fetch_addr; end
        if (!fetch_chain && nxt(mrp[dc], mlast[dc]) == mwp[dc]) marm[dc] = 0;
        mrp[dc] = nxt(mrp[dc], mlast[dc]);
        mlocked = fetch_chain;
        mlck = dc;
        if (!fetch_chain) served.push_back(dc);
      end
      if (cfg_we && cfg_ch < N) begin
        case (cfg_sel)
          3'd0: mbase[cfg_ch] = int'(cfg_data);
          3'd1: mlast[cfg_ch] = int'(cfg_data[7:0]);
          3'd2: mrp[cfg_ch]   = int'(cfg_data[7:0]);
          3'd3: mwp[cfg_ch]   = int'(cfg_data[7:0]);
          3'd4: begin
            men[cfg_ch] = cfg_data[0];
            if (!cfg_data[0]) begin
              marm[cfg_ch] = 0;
              if (mlocked && mlck == int'(cfg_ch)) mlocked = 0;
            end
          end
          default: ;
        endcase
      end
      if (db_we) begin
        if (db_ok) begin mwp[db_ch] = int'(db_wp); marm[db_ch] = 1; end
        else merr = 1;
      end
    end
  end

  task automatic cfg(input int ch, input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 8'(ch); cfg_sel = 3'(sel); cfg_data = 32'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ring(input int ch, input int wp);
    @(negedge clk);
    db_we = 1'b1; db_ch = 8'(ch); db_wp = 8'(wp);
    @(negedge clk);
    db_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int h0, f0;
    longint a0;
    idle(3);
    #2;
    chk(ring_empty == 4'hF, "R1 empty", ring_empty, 4'hF);
    chk(ring_full == 4'h0, "R1 full", ring_full, 0);
    chk(!fetch_valid && !db_err, "R1 idle", {fetch_valid, db_err}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 setup
    cfg(0, 0, 32'h1000); cfg(0, 1, 7); cfg(0, 4, 1);
    cfg(1, 0, 32'h2000); cfg(1, 1, 3); cfg(1, 2, 2); cfg(1, 3, 2); cfg(1, 4, 1);
    cfg(2, 0, 32'h3000); cfg(2, 1, 7); cfg(2, 4, 1);
    cfg(9, 3, 5);                                      // R3 ignored channel
    idle(1); #2;
    chk(ring_empty == 4'hF, "R3 out-of-range cfg ignored", ring_empty, 4'hF);

    // R4: write index by configuration only starts nothing
    cfg(0, 3, 3);
    f0 = fv_cnt;
    idle(6); #2;
    chk(!ring_empty[0], "R4 ring has work", ring_empty[0], 0);
    chk(fv_cnt == f0, "R4 no fetch without doorbell", fv_cnt - f0, 0);
    @(negedge clk); db_we = 1'b1; db_ch = 8'd0; db_wp = 8'd3;
    @(negedge clk); db_we = 1'b0; #2;
    chk(!fetch_valid, "R4 not yet valid", fetch_valid, 0);
    @(negedge clk); #2;
    chk(fetch_valid && fetch_first, "R4 valid after two edges", fetch_valid, 1);
    chk(fetch_addr == 32'h1000, "R6 first addr", fetch_addr, 32'h1000);
    h0 = hs_cnt;
    @(negedge clk); fetch_ready = 1'b1;
    idle(12); #2;
    chk(hs_cnt - h0 == 3, "R7 three elements", hs_cnt - h0, 3);
    chk(ring_empty[0] && !fetch_valid, "R10 idle when drained", fetch_valid, 0);

    // R8: chained descriptor 3,4 then 5 after running dry
    chain_mask = 8'b0001_1000;
    h0 = hs_cnt;
    ring(0, 5);
    idle(10); #2;
    chk(hs_cnt - h0 == 2, "R8 two chained elements", hs_cnt - h0, 2);
    chk(!fetch_valid && ring_empty[0], "R8 waiting mid-descriptor", fetch_valid, 0);
    f0 = ch1_hs;
    ring(1, 1);
    idle(8); #2;
    chk(ch1_hs == f0, "R8 other channel held off", ch1_hs - f0, 0);
    ring(0, 6);
    idle(20); #2;
    chk(ch1_hs - f0 == 3, "R2 wrap elements", ch1_hs - f0, 3);
    chk(last_ch1_addr == 32'h2000, "R2 wrapped to index 0", last_ch1_addr, 32'h2000);
    chk(ring_empty == 4'hF, "R10 all drained", ring_empty, 4'hF);

    // R2 full and R7 stall
    chain_mask = 8'h00;
    @(negedge clk); fetch_ready = 1'b0;
    ring(0, 5);
    idle(3); #2;
    chk(ring_full[0], "R2 full", ring_full[0], 1);
    a0 = fetch_addr; h0 = hs_cnt;
    idle(5); #2;
    chk(fetch_valid && fetch_addr == a0 && hs_cnt == h0, "R7 stall holds", fetch_addr, a0);
    @(negedge clk); fetch_ready = 1'b1;
    idle(25); #2;
    chk(hs_cnt - h0 == 7, "R7 drained seven", hs_cnt - h0, 7);

    // R9 round robin
    @(negedge clk); fetch_ready = 1'b0;
    ring(0, 7); ring(1, 3); ring(2, 2);
    served.delete();
    @(negedge clk); fetch_ready = 1'b1;
    idle(30); #2;
    chk(served.size() == 6, "R9 six descriptors", served.size(), 6);
    if (served.size() == 6) begin
      for (int k = 0; k < 6; k++)
        chk(served[k] == k % 3, "R9 order", served[k], k % 3);
    end

    // R5 rejected doorbells
    chk(!db_err, "R5 clear before", db_err, 0);
    f0 = fv_cnt;
    ring(9, 0);
    idle(1); #2;
    chk(db_err, "R5 unsupported channel", db_err, 1);
    ring(3, 1);
    ring(1, 5);
    idle(4); #2;
    chk(ring_empty == 4'hF && fv_cnt == f0, "R5 ignored doorbells", ring_empty, 4'hF);
    h0 = hs_cnt;
    ring(2, 3);
    idle(8); #2;
    chk(hs_cnt - h0 == 1 && db_err, "R5 sticky after good doorbell", db_err, 1);

    // R3 disable keeps indices and stops fetch
    @(negedge clk); fetch_ready = 1'b0;
    ring(2, 5);
    idle(3); #2;
    chk(fetch_valid, "R3 offer pending", fetch_valid, 1);
    cfg(2, 4, 0);
    idle(2); #2;
    chk(!fetch_valid && !ring_empty[2], "R3 disabled keeps work", fetch_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule